// File: doc/BRIEF.md
# Debug Resource Ownership Controller

This block arbitrates each of a set of debug resources (breakpoint and watchpoint comparators, counters and similar) between two masters: software running on the core and an external hardware debugger. A single external-debug enable, writable only by the hardware debugger, hands every resource to the debugger. A per-resource grant-back mask then returns chosen resources to software. Ownership decides three things: which status register a resource's events are recorded in, whether those events can ever raise a debug interrupt, and whether software may write that resource's control state.

Each resource has an event-enable bit, and events on disabled resources are discarded. Software and the debugger each have a write channel built as a valid/ready stream. Both channels hold ready high from the first clock edge after reset and never apply back-pressure. A transfer happens in any cycle where valid and ready are both high. Each software transfer is answered one cycle later by exactly one pulse, either accept or reject. A rejected transfer changes no state.

Top module: `dbg_own_ctrl`

## Requirements
- R1: After reset, both status registers, the event enables, the grant mask, the external-debug enable, the internal-debug enable, the interrupt and both write-outcome pulses are all 0. Both ready outputs are 0 during reset and 1 from the first clock edge after reset.
- R2: The external-debug enable appears identically on two outputs, one for the debugger view and one for the software view. It changes only through a debugger transfer with op 0, which loads mask bit 0. A software control transfer (op 2) with mask bit 1 set leaves it unchanged.
- R3: A resource is hardware-owned when the external-debug enable is 1 and its grant bit is 0. An event pulse on an enabled hardware-owned resource sets its bit in the debugger status on the next edge. This holds for any value of the global interrupt enable.
- R4: An event pulse on an enabled software-owned resource sets its bit in the software status on the next edge.
- R5: The debug interrupt is registered. It is 1 in the cycle after a cycle in which the internal-debug enable, the global interrupt enable and at least one software status bit of a software-owned resource were all 1. In every other case it is 0.
- R6: While external debug is enabled, a hardware-owned resource never sets a software status bit and never contributes to the interrupt, even with the internal-debug enable set.
- R7: A software transfer with op 0 (event-enable write) or op 1 (status clear) is rejected if its mask includes any hardware-owned resource. A rejected transfer has no effect and gives a one-cycle reject pulse. Any other software transfer gives a one-cycle accept pulse.
- R8: A debugger transfer with op 1 loads the grant mask. Granted resources act as software-owned for routing, for the interrupt and for software writes while external debug is enabled.
- R9: Status bits are sticky and cleared by writing 1 through the owner's channel: software op 1 for the software status, debugger op 3 for the debugger status, which only clears hardware-owned bits. When an event and a clear hit the same bit in one cycle, the event wins.
- R10: Software op 0 writes the value bit into the event enable of every masked resource. Debugger op 2 does the same, but only for hardware-owned resources. Events on disabled resources are ignored.
- R11: Each software transfer produces exactly one accept or reject pulse, and only on the cycle after the transfer. Software op 2 loads the internal-debug enable from mask bit 0. Software op 3 is accepted and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_wr_valid | input | 1 | Debugger write valid |
| hw_wr_ready | output | 1 | Debugger write ready |
| hw_wr_op | input | 2 | Debugger op: 0 ext enable, 1 grant, 2 event enable, 3 status clear |
| hw_wr_mask | input | N_RES | Debugger resource mask or data |
| hw_wr_val | input | 1 | Debugger enable value for op 2 |
| sw_wr_valid | input | 1 | Software write valid |
| sw_wr_ready | output | 1 | Software write ready |
| sw_wr_op | input | 2 | Software op: 0 event enable, 1 status clear, 2 control, 3 none |
| sw_wr_mask | input | N_RES | Software resource mask or data |
| sw_wr_val | input | 1 | Software enable value for op 0 |
| dbg_int_en | input | 1 | Global debug-interrupt enable |
| evt_pulse | input | N_RES | Per-resource event pulses |
| hw_sts | output | N_RES | Debugger status register |
| sw_sts | output | N_RES | Software status register |
| dbg_irq | output | 1 | Debug interrupt request |
| sw_wr_accept | output | 1 | Software transfer accepted (one cycle) |
| sw_wr_reject | output | 1 | Software transfer rejected (one cycle) |
| ext_en_hw_view | output | 1 | External-debug enable, debugger view |
| ext_en_sw_view | output | 1 | External-debug enable, software view |

## Verification
The hardest case to reach from the ports is a resource whose ownership changes while it still holds status. One example is a software status bit left set when the debugger takes external control: it must stop driving the interrupt, resist software clears, and then drive the interrupt again once control is dropped. Another is an event and a clear landing on the same bit in one cycle. The directed stimulus builds these states by first arming enables and status under software, then switching ownership through the debugger channel with grant masks that split the resource set. After that, a long run of random transfers on both channels, together with random events, is compared against a model of the ownership rules.

// File: rtl/dbg_own_pkg.sv
package dbg_own_pkg;

  typedef enum logic [1:0] {
    SW_OP_EN  = 2'd0,
    SW_OP_CLR = 2'd1,
    SW_OP_CTL = 2'd2,
    SW_OP_NOP = 2'd3
  } sw_op_e;

  typedef enum logic [1:0] {
    HW_OP_EXT   = 2'd0,
    HW_OP_GRANT = 2'd1,
    HW_OP_EN    = 2'd2,
    HW_OP_CLR   = 2'd3
  } hw_op_e;

endpackage

// File: rtl/dbg_own_ctl.sv
module dbg_own_ctl
  import dbg_own_pkg::*;
#(
  parameter int N_RES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_fire,
  input  logic [1:0]       hw_op,
  input  logic [N_RES-1:0] hw_mask,
  input  logic             sw_ctl_fire,
  input  logic             sw_ctl_bit,
  output logic             ext_en,
  output logic             idbg_en,
  output logic [N_RES-1:0] grant,
  output logic [N_RES-1:0] hw_own
);

  hw_op_e hop;
  assign hop = hw_op_e'(hw_op);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_en  <= 1'b0;
      idbg_en <= 1'b0;
      grant   <= '0;
    end else begin
      if (hw_fire && hop == HW_OP_EXT)   ext_en <= hw_mask[0];
      if (hw_fire && hop == HW_OP_GRANT) grant  <= hw_mask;
      if (sw_ctl_fire)                   idbg_en <= sw_ctl_bit;
    end
  end

  // External enable overrides internal debug for every non-granted resource.
  assign hw_own = ext_en ? ~grant : '0;

endmodule

// File: rtl/dbg_own_swgate.sv
module dbg_own_swgate
  import dbg_own_pkg::*;
#(
  parameter int N_RES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [1:0]       op,
  input  logic [N_RES-1:0] mask,
  input  logic [N_RES-1:0] hw_own,
  output logic             ready,
  output logic             accept,
  output logic             reject,
  output logic             en_fire,
  output logic             clr_fire,
  output logic             ctl_fire
);

  sw_op_e sop;
  logic   fire;
  logic   guarded;
  logic   blocked;

  assign sop     = sw_op_e'(op);
  assign fire    = valid && ready;
  assign guarded = (sop == SW_OP_EN) || (sop == SW_OP_CLR);
  assign blocked = guarded && (|(mask & hw_own));

  assign en_fire  = fire && !blocked && (sop == SW_OP_EN);
  assign clr_fire = fire && !blocked && (sop == SW_OP_CLR);
  assign ctl_fire = fire && (sop == SW_OP_CTL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready  <= 1'b0;
      accept <= 1'b0;
      reject <= 1'b0;
    end else begin
      ready  <= 1'b1;
      accept <= fire && !blocked;
      reject <= fire && blocked;
    end
  end

endmodule

// File: rtl/dbg_own_cell.sv
module dbg_own_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic own_hw,
  input  logic evt,
  input  logic sw_en_we,
  input  logic sw_en_val,
  input  logic hw_en_we,
  input  logic hw_en_val,
  input  logic sw_clr,
  input  logic hw_clr,
  output logic en,
  output logic hsts,
  output logic ssts
);

  logic hit;
  assign hit = evt && en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      hsts <= 1'b0;
      ssts <= 1'b0;
    end else begin
      if (sw_en_we)      en <= sw_en_val;
      else if (hw_en_we) en <= hw_en_val;
      // event set takes precedence over a same-cycle clear
      hsts <= (hit && own_hw)  || (hsts && !hw_clr);
      ssts <= (hit && !own_hw) || (ssts && !sw_clr);
    end
  end

endmodule

// File: rtl/dbg_own_route.sv
module dbg_own_route #(
  parameter int N_RES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_RES-1:0] hw_own,
  input  logic [N_RES-1:0] evt,
  input  logic             dbg_int_en,
  input  logic             idbg_en,
  input  logic             sw_en_fire,
  input  logic             sw_clr_fire,
  input  logic [N_RES-1:0] sw_mask,
  input  logic             sw_val,
  input  logic             hw_en_fire,
  input  logic             hw_clr_fire,
  input  logic [N_RES-1:0] hw_mask,
  input  logic             hw_val,
  output logic [N_RES-1:0] res_en,
  output logic [N_RES-1:0] hw_sts,
  output logic [N_RES-1:0] sw_sts,
  output logic             irq
);

  logic [N_RES-1:0] sw_en_we;
  logic [N_RES-1:0] hw_en_we;
  logic [N_RES-1:0] sw_clr;
  logic [N_RES-1:0] hw_clr;
  logic             sw_pending;

  assign sw_en_we = sw_en_fire  ? sw_mask : '0;
  assign sw_clr   = sw_clr_fire ? sw_mask : '0;
  assign hw_en_we = hw_en_fire  ? (hw_mask & hw_own) : '0;
  assign hw_clr   = hw_clr_fire ? (hw_mask & hw_own) : '0;

  for (genvar i = 0; i < N_RES; i++) begin : g_res
    dbg_own_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .own_hw    (hw_own[i]),
      .evt       (evt[i]),
      .sw_en_we  (sw_en_we[i]),
      .sw_en_val (sw_val),
      .hw_en_we  (hw_en_we[i]),
      .hw_en_val (hw_val),
      .sw_clr    (sw_clr[i]),
      .hw_clr    (hw_clr[i]),
      .en        (res_en[i]),
      .hsts      (hw_sts[i]),
      .ssts      (sw_sts[i])
    );
  end

  assign sw_pending = |(sw_sts & ~hw_own);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= idbg_en && dbg_int_en && sw_pending;
  end

endmodule

// File: rtl/dbg_own_ctrl.sv
module dbg_own_ctrl
  import dbg_own_pkg::*;
#(
  parameter int N_RES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_wr_valid,
  output logic             hw_wr_ready,
  input  logic [1:0]       hw_wr_op,
  input  logic [N_RES-1:0] hw_wr_mask,
  input  logic             hw_wr_val,
  input  logic             sw_wr_valid,
  output logic             sw_wr_ready,
  input  logic [1:0]       sw_wr_op,
  input  logic [N_RES-1:0] sw_wr_mask,
  input  logic             sw_wr_val,
  input  logic             dbg_int_en,
  input  logic [N_RES-1:0] evt_pulse,
  output logic [N_RES-1:0] hw_sts,
  output logic [N_RES-1:0] sw_sts,
  output logic             dbg_irq,
  output logic             sw_wr_accept,
  output logic             sw_wr_reject,
  output logic             ext_en_hw_view,
  output logic             ext_en_sw_view
);

  logic             hw_fire;
  logic             ext_en;
  logic             idbg_en;
  logic [N_RES-1:0] grant;
  logic [N_RES-1:0] hw_own;
  logic [N_RES-1:0] res_en;
  logic             sw_en_fire;
  logic             sw_clr_fire;
  logic             sw_ctl_fire;
  logic             hw_en_fire;
  logic             hw_clr_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) hw_wr_ready <= 1'b0;
    else        hw_wr_ready <= 1'b1;
  end

  assign hw_fire     = hw_wr_valid && hw_wr_ready;
  assign hw_en_fire  = hw_fire && (hw_op_e'(hw_wr_op) == HW_OP_EN);
  assign hw_clr_fire = hw_fire && (hw_op_e'(hw_wr_op) == HW_OP_CLR);

  dbg_own_ctl #(.N_RES(N_RES)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_fire     (hw_fire),
    .hw_op       (hw_wr_op),
    .hw_mask     (hw_wr_mask),
    .sw_ctl_fire (sw_ctl_fire),
    .sw_ctl_bit  (sw_wr_mask[0]),
    .ext_en      (ext_en),
    .idbg_en     (idbg_en),
    .grant       (grant),
    .hw_own      (hw_own)
  );

  dbg_own_swgate #(.N_RES(N_RES)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (sw_wr_valid),
    .op       (sw_wr_op),
    .mask     (sw_wr_mask),
    .hw_own   (hw_own),
    .ready    (sw_wr_ready),
    .accept   (sw_wr_accept),
    .reject   (sw_wr_reject),
    .en_fire  (sw_en_fire),
    .clr_fire (sw_clr_fire),
    .ctl_fire (sw_ctl_fire)
  );

  dbg_own_route #(.N_RES(N_RES)) u_route (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_own      (hw_own),
    .evt         (evt_pulse),
    .dbg_int_en  (dbg_int_en),
    .idbg_en     (idbg_en),
    .sw_en_fire  (sw_en_fire),
    .sw_clr_fire (sw_clr_fire),
    .sw_mask     (sw_wr_mask),
    .sw_val      (sw_wr_val),
    .hw_en_fire  (hw_en_fire),
    .hw_clr_fire (hw_clr_fire),
    .hw_mask     (hw_wr_mask),
    .hw_val      (hw_wr_val),
    .res_en      (res_en),
    .hw_sts      (hw_sts),
    .sw_sts      (sw_sts),
    .irq         (dbg_irq)
  );

  assign ext_en_hw_view = ext_en;
  assign ext_en_sw_view = ext_en;

endmodule

// File: rtl/dbg_own_chk.sv
module dbg_own_chk #(
  parameter int N_RES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hw_wr_valid,
  input logic             hw_wr_ready,
  input logic [1:0]       hw_wr_op,
  input logic             sw_wr_valid,
  input logic             sw_wr_ready,
  input logic [1:0]       sw_wr_op,
  input logic [N_RES-1:0] sw_wr_mask,
  input logic             dbg_int_en,
  input logic [N_RES-1:0] evt_pulse,
  input logic [N_RES-1:0] hw_sts,
  input logic [N_RES-1:0] sw_sts,
  input logic             dbg_irq,
  input logic             sw_wr_accept,
  input logic             sw_wr_reject,
  input logic             ext_en,
  input logic             idbg_en,
  input logic [N_RES-1:0] hw_own,
  input logic [N_RES-1:0] res_en
);

  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_wr_accept && sw_wr_reject));

  assert_outcome_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_accept || sw_wr_reject) |-> $past(sw_wr_valid && sw_wr_ready));

  assert_reject_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_reject |-> $past((sw_wr_op == 2'd0 || sw_wr_op == 2'd1) && (|(sw_wr_mask & hw_own))));

  assert_hw_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_pulse & res_en & hw_own)) |=>
      ((hw_sts & $past(evt_pulse & res_en & hw_own)) == $past(evt_pulse & res_en & hw_own)));

  assert_no_sw_leak_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sw_sts & ~$past(sw_sts) & $past(hw_own))) == 1'b0);

  assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_irq |-> $past(idbg_en && dbg_int_en));

  assert_ext_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ext_en) |-> $past(hw_wr_valid && hw_wr_ready && hw_wr_op == 2'd0));

  assert_sticky_sw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(sw_sts) & ~sw_sts)) |-> $past(sw_wr_valid && sw_wr_ready && sw_wr_op == 2'd1));

endmodule

bind dbg_own_ctrl dbg_own_chk #(.N_RES(N_RES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hw_wr_valid  (hw_wr_valid),
  .hw_wr_ready  (hw_wr_ready),
  .hw_wr_op     (hw_wr_op),
  .sw_wr_valid  (sw_wr_valid),
  .sw_wr_ready  (sw_wr_ready),
  .sw_wr_op     (sw_wr_op),
  .sw_wr_mask   (sw_wr_mask),
  .dbg_int_en   (dbg_int_en),
  .evt_pulse    (evt_pulse),
  .hw_sts       (hw_sts),
  .sw_sts       (sw_sts),
  .dbg_irq      (dbg_irq),
  .sw_wr_accept (sw_wr_accept),
  .sw_wr_reject (sw_wr_reject),
  .ext_en       (ext_en),
  .idbg_en      (idbg_en),
  .hw_own       (hw_own),
  .res_en       (res_en)
);

// File: tb/dbg_own_ctrl_tb.sv
module dbg_own_ctrl_tb;

  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hw_wr_valid = 1'b0;
  logic         hw_wr_ready;
  logic [1:0]   hw_wr_op = '0;
  logic [N-1:0] hw_wr_mask = '0;
  logic         hw_wr_val = 1'b0;
  logic         sw_wr_valid = 1'b0;
  logic         sw_wr_ready;
  logic [1:0]   sw_wr_op = '0;
  logic [N-1:0] sw_wr_mask = '0;
  logic         sw_wr_val = 1'b0;
  logic         dbg_int_en = 1'b0;
  logic [N-1:0] evt_pulse = '0;
  logic [N-1:0] hw_sts;
  logic [N-1:0] sw_sts;
  logic         dbg_irq;
  logic         sw_wr_accept;
  logic         sw_wr_reject;
  logic         ext_en_hw_view;
  logic         ext_en_sw_view;

  always #4 clk = ~clk;

  dbg_own_ctrl #(.N_RES(N)) u_dut (.*);

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int           due;
    logic [N-1:0] hws;
    logic [N-1:0] sws;
    logic         irq;
    logic         acc;
    logic         rej;
    logic         ext;
    string        tag;
  } exp_t;

  exp_t q[$];

  // requirement-level model state
  logic         m_ext = 0, m_idbg = 0;
  logic [N-1:0] m_grant = '0, m_en = '0, m_hws = '0, m_sws = '0;

  task automatic chk(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops items that fall due this cycle
  always @(posedge clk) begin
    #6;
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "hw_sts", hw_sts, e.hws);
      chk(e.tag, "sw_sts", sw_sts, e.sws);
      chk(e.tag, "dbg_irq", {15'd0, dbg_irq}, {15'd0, e.irq});
      chk(e.tag, "accept", {15'd0, sw_wr_accept}, {15'd0, e.acc});
      chk(e.tag, "reject", {15'd0, sw_wr_reject}, {15'd0, e.rej});
      chk({e.tag, "/R2"}, "ext views", {14'd0, ext_en_hw_view, ext_en_sw_view}, {14'd0, e.ext, e.ext});
      chk({e.tag, "/R1"}, "ready", {14'd0, hw_wr_ready, sw_wr_ready}, 16'h0003);
    end
  end

  task automatic step(input logic hv, input logic [1:0] hop, input logic [N-1:0] hm,
                      input logic hval, input logic sv, input logic [1:0] sop,
                      input logic [N-1:0] sm, input logic sval, input logic [N-1:0] ev,
                      input logic die, input string tag);
    exp_t e;
    logic [N-1:0] own, hit;
    logic blocked;
    @(posedge clk);
    #1;
    hw_wr_valid = hv; hw_wr_op = hop; hw_wr_mask = hm; hw_wr_val = hval;
    sw_wr_valid = sv; sw_wr_op = sop; sw_wr_mask = sm; sw_wr_val = sval;
    evt_pulse = ev; dbg_int_en = die;

    own = m_ext ? ~m_grant : '0;
    e.due = cyc + 1;
    e.tag = tag;
    e.irq = m_idbg && die && (|(m_sws & ~own));
    blocked = (sop == 2'd0 || sop == 2'd1) && (|(sm & own));
    e.acc = sv && !blocked;
    e.rej = sv && blocked;
    hit = ev & m_en;
    if (hv) begin
      case (hop)
        2'd0: m_ext = hm[0];
        2'd1: m_grant = hm;
        2'd2: m_en = hval ? (m_en | (hm & own)) : (m_en & ~(hm & own));
        default: m_hws = m_hws & ~(hm & own);
      endcase
    end
    if (sv && !blocked) begin
      case (sop)
        2'd0: m_en = sval ? (m_en | sm) : (m_en & ~sm);
        2'd1: m_sws = m_sws & ~sm;
        2'd2: m_idbg = sm[0];
        default: ;
      endcase
    end
    m_hws = m_hws | (hit & own);
    m_sws = m_sws | (hit & ~own);
    e.hws = m_hws;
    e.sws = m_sws;
    e.ext = m_ext;
    q.push_back(e);
  endtask

  task automatic idle(input logic die, input string tag);
    step(0, 2'd0, '0, 0, 0, 2'd0, '0, 0, '0, die, tag);
  endtask
  task automatic sw(input logic [1:0] op, input logic [N-1:0] m, input logic v,
                    input logic [N-1:0] ev, input logic die, input string tag);
    step(0, 2'd0, '0, 0, 1, op, m, v, ev, die, tag);
  endtask
  task automatic hw(input logic [1:0] op, input logic [N-1:0] m, input logic v,
                    input logic [N-1:0] ev, input logic die, input string tag);
    step(1, op, m, v, 0, 2'd0, '0, 0, ev, die, tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "reset status", hw_sts | sw_sts, '0);
    chk("R1", "reset pulses", {12'd0, dbg_irq, sw_wr_accept, sw_wr_reject, ext_en_hw_view}, '0);
    chk("R1", "reset ready", {14'd0, hw_wr_ready, sw_wr_ready}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    idle(1, "R1 idle");
    // enable all resources from software, then internal debug; try to set ext from software
    sw(2'd0, 16'hFFFF, 1, '0, 1, "R10 sw enable all");
    sw(2'd2, 16'h0003, 0, '0, 1, "R2 sw ctl ext attempt");
    sw(2'd3, 16'hFFFF, 0, '0, 1, "R11 sw nop accept");
    idle(1, "R2 ext unchanged");
    // software-owned events and interrupt
    step(0, 2'd0, '0, 0, 0, 2'd0, '0, 0, 16'h0005, 1, "R4 sw event");
    idle(1, "R5 irq raised");
    idle(0, "R5 irq masked by global enable");
    sw(2'd1, 16'h0001, 0, '0, 1, "R9 sw clear bit0");
    // set wins over clear on the same bit
    sw(2'd1, 16'h0004, 0, 16'h0004, 1, "R9 set beats clear");
    // debugger takes ownership
    hw(2'd0, 16'h0001, 0, '0, 1, "R2 hw sets ext");
    idle(1, "R6 owned status no irq");
    hw(2'd0, 16'h0000, 0, 16'h00F0, 0, "R3 hw event global off");
    step(0, 2'd0, '0, 0, 0, 2'd0, '0, 0, 16'h00F0, 1, "R6 hw event ignores idbg");
    // ext was cleared above; set again and test blocked writes
    hw(2'd0, 16'h0001, 0, '0, 1, "R2 hw sets ext again");
    sw(2'd0, 16'h0010, 0, '0, 1, "R7 blocked enable write");
    hw(2'd3, 16'h0010, 0, '0, 1, "R9 hw clear bit4");
    step(0, 2'd0, '0, 0, 0, 2'd0, '0, 0, 16'h0010, 1, "R7 enable kept after reject");
    sw(2'd1, 16'h0004, 0, '0, 1, "R9 sw clear blocked when owned");
    sw(2'd2, 16'h0001, 0, '0, 1, "R11 ctl accepted under ext");
    // grant-back
    hw(2'd1, 16'h0003, 0, '0, 1, "R8 grant 0,1");
    sw(2'd0, 16'h0002, 0, '0, 1, "R8 granted write accepted");
    step(0, 2'd0, '0, 0, 0, 2'd0, '0, 0, 16'h0103, 1, "R10 disabled bit1 ignored");
    idle(1, "R8 granted irq");
    hw(2'd2, 16'h0020, 0, '0, 1, "R10 hw disables bit5");
    step(0, 2'd0, '0, 0, 0, 2'd0, '0, 0, 16'h0020, 1, "R10 bit5 event dropped");
    hw(2'd3, 16'hFFFF, 0, '0, 1, "R9 hw clear owned only");
    hw(2'd2, 16'h0002, 1, '0, 1, "R10 hw cannot enable granted");
    step(0, 2'd0, '0, 0, 0, 2'd0, '0, 0, 16'h0002, 1, "R10 granted stays disabled");
    hw(2'd0, 16'h0000, 0, '0, 1, "R2 hw clears ext");
    idle(1, "R5 irq back after release");
    idle(1, "R9 hw status sticky");

    for (int i = 0; i < 600; i++) begin
      logic [N-1:0] hm, sm;
      hm = ($urandom % 3 == 0) ? N'($urandom) : (N'(1) << ($urandom % N));
      sm = ($urandom % 3 == 0) ? N'($urandom) : (N'(1) << ($urandom % N));
      step(($urandom % 4) == 0, 2'($urandom), hm, 1'($urandom),
           ($urandom % 2) == 0, 2'($urandom), sm, 1'($urandom),
           N'($urandom) & N'($urandom), 1'($urandom % 4 != 0), "R3 R4 R7 random");
    end
    idle(1, "R11 drain");
    idle(1, "R11 drain");
    repeat (3) @(posedge clk);
    done = 1'b1;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL R11 queue actual=%0d expected=0", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule